// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a real address by reading a chain of in-memory translation tables, one request at a time. A table descriptor picked by the address-space mode sets where the walk starts. The walk can begin at any of four table levels: first region, second region, third region or segment. It always ends at a page table. At each level the walker issues one 64-bit entry read on a simple request/acknowledge memory port. It checks the entry's invalid and type fields and then descends to the next table.

A translation ends in one of two ways. A `done` pulse presents the real address and the read, write and execute permissions. A `fault` pulse presents a fault code and a translation-exception word, which is the page-aligned virtual address marked with the mode that was used. Addresses in the lowest 8 KB are relocated by the prefix register. A successful result inside RAM also produces a storage-key update that carries reference and change bits.

Top module: `pt_walker`

## Requirements
- R1: With `dat_on` low, `ra` equals the page-aligned virtual address, before prefixing (R11). No table read is issued and `perm_r`, `perm_w` and `perm_x` are all 1.
- R2: With `addr64` low, the virtual address is cut to its low 31 bits before any other step. This applies to both the result and the exception word.
- R3: Descriptor selection by `req_mode` works as follows. Values 0 and 1 select the primary descriptor and 3 selects the home descriptor. Value 2 selects the secondary descriptor for data accesses, and the result then has `perm_x`=0. Value 2 with an instruction fetch (`req_kind`=2) selects the primary descriptor, and the result then has `perm_r`=`perm_w`=0.
- R4: A descriptor's type field is bits [3:2]: 3 means first region, 2 second region, 1 third region and 0 segment. Before any read, the virtual address must fit that type. Type 2 requires bits 63:53 to be zero, type 1 requires bits 63:42 to be zero and type 0 requires bits 63:31 to be zero. Otherwise the walker faults with code 1 (specification).
- R5: Descriptor bit 5 (real space) skips the walk. In that case `ra` is the virtual address and no read is issued.
- R6: The walk issues exactly one 8-byte read per level, starting at the table named by the descriptor type. The byte offsets are (va>>50)&0x3ff8 for the first-region table, (va>>39)&0x3ff8 for second-region, (va>>28)&0x3ff8 for third-region, (va>>17)&0x3ff8 for segment and (va>>9)&0x7f8 for the page table. Region and descriptor origins are bits [63:12]. The page-table origin is segment-entry bits [63:11].
- R7: In a region or segment entry, bit 5 set gives fault code 2. Otherwise, a type field [3:2] that differs from its own table's type gives code 1.
- R8: A page entry with bit 10 set gives fault code 3. Otherwise the frame is page-entry bits [63:12].
- R9: Page-entry bit 9 (read-only) clears `perm_w`. A write (`req_kind`=1) to such a page gives fault code 4 (protection).
- R10: On a fault, `xword` is the page-aligned virtual address with bits [1:0] set to the mode actually used (1 primary, 2 secondary, 3 home). Bit 2 is set for protection faults only.
- R11: A result below 0x2000 has `prefix` added to it.
- R12: With `done` high and the result below `RAM_TOP`, `key_we` is 1, `key_idx` is result bits [12 +: KEY_W], `key_ref` equals `perm_r` and `key_chg` equals `perm_w`. In all other cases `key_we` is 0.
- R13: `done` and `fault` are mutually exclusive single-cycle pulses that end each accepted request. `busy` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a translation (sampled when idle) |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_mode | input | 2 | Address-space mode: 1 primary, 2 secondary, 3 home |
| dat_on | input | 1 | Translation enable |
| addr64 | input | 1 | 64-bit addressing (low: 31-bit) |
| desc_pri | input | 64 | Primary table descriptor |
| desc_sec | input | 64 | Secondary table descriptor |
| desc_home | input | 64 | Home table descriptor |
| prefix | input | 64 | Low-core relocation base |
| busy | output | 1 | Translation in progress |
| mem_req | output | 1 | One-cycle entry read request |
| mem_addr | output | 64 | Entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Faulting completion pulse |
| fcode | output | 3 | Fault code 1..4 |
| xword | output | 64 | Translation-exception word |
| ra | output | 64 | Real address, valid with done |
| perm_r | output | 1 | Read permission |
| perm_w | output | 1 | Write permission |
| perm_x | output | 1 | Execute permission |
| key_we | output | 1 | Storage-key update strobe |
| key_idx | output | KEY_W | Page index of the key |
| key_ref | output | 1 | Set reference bit |
| key_chg | output | 1 | Set change bit |

## Verification
The bench builds the walker with `RAM_TOP` at 256 KB and `KEY_W` at 6. With these values, randomly placed frames fall on both sides of the RAM boundary. Prefix-relocated results can also move across it, so the presence and absence of the key update are both exercised, and the 6-bit key index can be compared directly. Fresh table trees are built for every request, with start types, single-level entry corruptions, read-only pages and both page-table half alignments chosen at random.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter logic [63:0] RAM_TOP = 64'h0000_0000_0100_0000,
  parameter int KEY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      req_va,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_mode,
  input  logic             dat_on,
  input  logic             addr64,
  input  logic [63:0]      desc_pri,
  input  logic [63:0]      desc_sec,
  input  logic [63:0]      desc_home,
  input  logic [63:0]      prefix,
  output logic             busy,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  output logic             done,
  output logic             fault,
  output logic [2:0]       fcode,
  output logic [63:0]      xword,
  output logic [63:0]      ra,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             key_we,
  output logic [KEY_W-1:0] key_idx,
  output logic             key_ref,
  output logic             key_chg
);
  localparam logic [63:0] LOWCORE = 64'h2000;
  localparam logic [2:0]  PG_TBL  = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FETCH, S_WAIT, S_DECODE, S_DONE, S_FAULT} st_t;
  st_t st;

  logic [63:0] va, cur, ent, ra_q, offs;
  logic [2:0]  tbl;
  logic [1:0]  kind_q, mode_q;
  logic        dat_q, pw, sec_f, sec_d, rng_bad;

  wire [63:0] va_in  = addr64 ? {req_va[63:12], 12'b0} : {33'b0, req_va[30:12], 12'b0};
  wire        fetch2 = (req_mode == 2'd2) && (req_kind == 2'd2);
  wire [1:0]  use_md = (fetch2 || req_mode == 2'd0) ? 2'd1 : req_mode;
  wire [1:0]  dtype  = cur[3:2];
  wire [2:0]  start  = 3'd3 - {1'b0, dtype};
  wire [63:0] org    = (tbl == PG_TBL) ? {cur[63:11], 11'b0} : {cur[63:12], 12'b0};
  wire [1:0]  exp_ty = 2'(3'd3 - tbl);

  always_comb begin
    case (tbl)
      3'd0:    offs = (va >> 50) & 64'h3ff8;
      3'd1:    offs = (va >> 39) & 64'h3ff8;
      3'd2:    offs = (va >> 28) & 64'h3ff8;
      3'd3:    offs = (va >> 17) & 64'h3ff8;
      default: offs = (va >> 9)  & 64'h07f8;
    endcase
    case (dtype)
      2'd2:    rng_bad = |va[63:53];
      2'd1:    rng_bad = |va[63:42];
      2'd0:    rng_bad = |va[63:31];
      default: rng_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; va <= '0; cur <= '0; ent <= '0; ra_q <= '0; tbl <= '0;
      kind_q <= '0; mode_q <= 2'd1; dat_q <= 1'b0; pw <= 1'b1;
      sec_f <= 1'b0; sec_d <= 1'b0; fcode <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va     <= va_in;
          kind_q <= req_kind;
          mode_q <= use_md;
          dat_q  <= dat_on;
          pw     <= 1'b1;
          sec_f  <= dat_on && fetch2;
          sec_d  <= dat_on && (req_mode == 2'd2) && !fetch2;
          cur    <= (use_md == 2'd2) ? desc_sec : (use_md == 2'd3) ? desc_home : desc_pri;
          st     <= S_CHECK;
        end
        S_CHECK:
          if (!dat_q || cur[5]) begin ra_q <= va; st <= S_DONE; end
          else if (rng_bad) begin fcode <= 3'd1; st <= S_FAULT; end
          else begin tbl <= start; st <= S_FETCH; end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_ack) begin ent <= mem_rdata; st <= S_DECODE; end
        S_DECODE:
          if (tbl != PG_TBL) begin
            if (ent[5])                   begin fcode <= 3'd2; st <= S_FAULT; end
            else if (ent[3:2] != exp_ty)  begin fcode <= 3'd1; st <= S_FAULT; end
            else begin cur <= ent; tbl <= tbl + 3'd1; st <= S_FETCH; end
          end else begin
            if (ent[10])                          begin fcode <= 3'd3; st <= S_FAULT; end
            else if (ent[9] && kind_q == 2'd1)    begin fcode <= 3'd4; st <= S_FAULT; end
            else begin pw <= !ent[9]; ra_q <= {ent[63:12], 12'b0}; st <= S_DONE; end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_FETCH);
  assign mem_addr = org + offs;
  assign done     = (st == S_DONE);
  assign fault    = (st == S_FAULT);
  assign xword    = {va[63:3], fcode == 3'd4, mode_q};
  assign ra       = (ra_q < LOWCORE) ? ra_q + prefix : ra_q;
  assign perm_r   = !sec_f;
  assign perm_w   = pw && !sec_f;
  assign perm_x   = !sec_d;
  assign key_we   = done && (ra < RAM_TOP);
  assign key_idx  = ra[12 +: KEY_W];
  assign key_ref  = perm_r;
  assign key_chg  = perm_w;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [2:0]  fcode,
  input logic [63:0] xword,
  input logic        perm_r,
  input logic        perm_w,
  input logic        key_we,
  input logic        key_ref,
  input logic        key_chg
);
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[2:0] == 3'd0); // R6
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R6
  AST_END_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R13
  AST_END_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> !(done || fault)); // R13
  AST_READ_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R13
  AST_FAULT_CODE:  assert property (@(posedge clk) disable iff (!rst_n) fault |-> (fcode >= 3'd1 && fcode <= 3'd4)); // R7
  AST_XWORD_MODE:  assert property (@(posedge clk) disable iff (!rst_n) fault |-> xword[1:0] != 2'd0); // R10
  AST_XWORD_PROT:  assert property (@(posedge clk) disable iff (!rst_n) fault |-> xword[2] == (fcode == 3'd4)); // R10
  AST_KEY_BITS:    assert property (@(posedge clk) disable iff (!rst_n) key_we |-> (done && key_ref == perm_r && key_chg == perm_w)); // R12
  AST_SEC_FETCH:   assert property (@(posedge clk) disable iff (!rst_n) (done && !perm_r) |-> !perm_w); // R3
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
  .done(done), .fault(fault), .fcode(fcode), .xword(xword), .perm_r(perm_r),
  .perm_w(perm_w), .key_we(key_we), .key_ref(key_ref), .key_chg(key_chg)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  localparam logic [63:0] RAM_TOP = 64'h0004_0000;
  localparam int KEY_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, dat_on = 1'b0, addr64 = 1'b1, mem_ack = 1'b0;
  logic [63:0] req_va = '0, desc_pri = '0, desc_sec = '0, desc_home = '0, prefix = '0, mem_rdata = '0;
  logic [1:0] req_kind = '0, req_mode = 2'd1;
  logic busy, mem_req, done, fault, perm_r, perm_w, perm_x, key_we, key_ref, key_chg;
  logic [63:0] mem_addr, xword, ra;
  logic [2:0] fcode;
  logic [KEY_W-1:0] key_idx;

  pt_walker #(.RAM_TOP(RAM_TOP), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
    .req_mode(req_mode), .dat_on(dat_on), .addr64(addr64), .desc_pri(desc_pri),
    .desc_sec(desc_sec), .desc_home(desc_home), .prefix(prefix), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fcode(fcode), .xword(xword), .ra(ra), .perm_r(perm_r),
    .perm_w(perm_w), .perm_x(perm_x), .key_we(key_we), .key_idx(key_idx),
    .key_ref(key_ref), .key_chg(key_chg));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_rd = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] next_tbl;

  logic e_fault, e_r, e_w, e_x, e_kwe;
  logic [2:0] e_code;
  logic [63:0] e_xw, e_ra;
  int e_reads;
  logic s_done, s_fault, s_r, s_w, s_x, s_kwe, s_ref, s_chg;
  logic [2:0] s_code;
  logic [63:0] s_xw, s_ra;
  logic [KEY_W-1:0] s_idx;

  task automatic chk(input bit ok, input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h420;
  endfunction

  function automatic logic [63:0] offb(input int k, input logic [63:0] v);
    case (k)
      0: return (v >> 50) & 64'h3ff8;
      1: return (v >> 39) & 64'h3ff8;
      2: return (v >> 28) & 64'h3ff8;
      3: return (v >> 17) & 64'h3ff8;
      default: return (v >> 9) & 64'h07f8;
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [63:0] a;
        int lat;
        a = mem_addr;
        n_rd++;
        lat = 1 + int'($urandom % 3);
        repeat (lat) @(negedge clk);
        mem_rdata = rd(a);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic build(input logic [63:0] v, input logic [1:0] ty, input int inj_lvl, input int inj_kind,
                       input bit ro, input logic [63:0] frame, output logic [63:0] dsg);
    logic [63:0] co, nx, e;
    mem.delete();
    next_tbl = 64'h0010_0000;
    co = next_tbl; next_tbl += 64'h1000;
    dsg = co | (64'(ty) << 2);
    for (int k = 3 - int'(ty); k <= 4; k++) begin
      if (k < 4) begin
        nx = next_tbl; next_tbl += 64'h1000;
        if (k == 3) nx = nx | (64'($urandom % 2) << 11);
        e = nx | (64'(3 - k) << 2);
        if (k == inj_lvl && inj_kind == 1) e = e | 64'h20;
        if (k == inj_lvl && inj_kind == 2) e = e ^ 64'h4;
        mem[co + offb(k, v)] = e;
        co = nx;
      end else begin
        e = {frame[63:12], 12'b0} | (64'(ro) << 9);
        if (k == inj_lvl && inj_kind == 1) e = e | 64'h400;
        mem[co + offb(k, v)] = e;
      end
    end
  endtask

  task automatic model(input logic [63:0] vr, input logic [1:0] kind, input logic [1:0] mode, input bit dat, input bit wide);
    logic [63:0] v, d, cur, e, lim;
    logic [1:0] um;
    bit sf, sd;
    v = wide ? {vr[63:12], 12'b0} : {33'b0, vr[30:12], 12'b0};
    e_fault = 0; e_code = 0; e_reads = 0; e_r = 1; e_w = 1; e_x = 1; e_ra = v;
    sf = (mode == 2) && (kind == 2);
    sd = (mode == 2) && !sf;
    um = (sf || mode == 0) ? 2'd1 : mode;
    d = (um == 2) ? desc_sec : (um == 3) ? desc_home : desc_pri;
    if (dat && !d[5]) begin
      lim = (d[3:2] == 2) ? 64'h001f_ffff_ffff_ffff : (d[3:2] == 1) ? 64'h0000_03ff_ffff_ffff :
            (d[3:2] == 0) ? 64'h0000_0000_7fff_ffff : '1;
      if (v > lim) begin e_fault = 1; e_code = 1; end
      else begin
        cur = d;
        for (int k = 3 - int'(d[3:2]); k <= 4; k++) begin
          e = rd(((k == 4) ? {cur[63:11], 11'b0} : {cur[63:12], 12'b0}) + offb(k, v));
          e_reads++;
          if (k < 4) begin
            if (e[5]) begin e_fault = 1; e_code = 2; break; end
            if (int'(e[3:2]) != 3 - k) begin e_fault = 1; e_code = 1; break; end
            cur = e;
          end else begin
            if (e[10]) begin e_fault = 1; e_code = 3; end
            else begin
              e_w = !e[9];
              if (e[9] && kind == 1) begin e_fault = 1; e_code = 4; end
              e_ra = {e[63:12], 12'b0};
            end
          end
        end
      end
    end
    if (dat && sf) begin e_r = 0; e_w = 0; end
    if (dat && sd) e_x = 0;
    e_xw = v | 64'(um) | ((e_code == 4) ? 64'h4 : 64'h0);
    if (e_ra < 64'h2000) e_ra = e_ra + prefix;
    e_kwe = !e_fault && (e_ra < RAM_TOP);
  endtask

  task automatic run(input logic [63:0] v, input logic [1:0] kind, input logic [1:0] mode, input bit dat, input bit wide);
    int waited;
    model(v, kind, mode, dat, wide);
    @(negedge clk);
    req_va = v; req_kind = kind; req_mode = mode; dat_on = dat; addr64 = wide;
    n_rd = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!(done || fault) && waited < 300) begin @(negedge clk); waited++; end
    s_done = done; s_fault = fault; s_code = fcode; s_xw = xword; s_ra = ra;
    s_r = perm_r; s_w = perm_w; s_x = perm_x; s_kwe = key_we; s_idx = key_idx; s_ref = key_ref; s_chg = key_chg;
    chk(s_fault == e_fault && s_done == !e_fault, "R13", "outcome", {s_fault, s_done}, {e_fault, !e_fault});
    chk(n_rd == e_reads, "R6", "reads", 64'(n_rd), 64'(e_reads));
    chk(s_kwe == e_kwe, "R12", "key_we", 64'(s_kwe), 64'(e_kwe));
    if (e_fault) begin
      chk(s_code == e_code, "R7", "fcode", 64'(s_code), 64'(e_code));
      chk(s_xw == e_xw, "R10", "xword", s_xw, e_xw);
    end else begin
      chk(s_ra == e_ra, "R11", "ra", s_ra, e_ra);
      chk({s_r, s_w, s_x} == {e_r, e_w, e_x}, "R3", "perms", 64'({s_r, s_w, s_x}), 64'({e_r, e_w, e_x}));
      if (e_kwe)
        chk({s_idx, s_ref, s_chg} == {e_ra[12 +: KEY_W], e_r, e_w}, "R12", "key fields",
            64'({s_idx, s_ref, s_chg}), 64'({e_ra[12 +: KEY_W], e_r, e_w}));
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] dsg, v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R13", "reset idle", {busy, done, fault, mem_req}, 64'h0);
    rst_n = 1'b1;
    prefix = 64'h0003_0000;
    desc_pri = 64'h20; desc_sec = 64'h20; desc_home = 64'h20;

    run(64'h0000_1234_5678_9abc, 2'd0, 2'd1, 1'b0, 1'b1);
    chk(s_ra == 64'h0000_1234_5678_9000 && n_rd == 0, "R1", "dat off pass", s_ra, 64'h0000_1234_5678_9000);
    run(64'h0000_0000_0000_1abc, 2'd1, 2'd1, 1'b0, 1'b1);
    chk(s_ra == 64'h31000 && s_kwe && s_idx == 6'h31, "R11", "low-core prefix", s_ra, 64'h31000);
    run(64'hffff_ffff_8765_4321, 2'd0, 2'd1, 1'b0, 1'b0);
    chk(s_ra == 64'h0765_4000, "R2", "31-bit mask", s_ra, 64'h0765_4000);

    desc_pri = 64'h0010_0000;
    run(64'h0000_0000_8000_0000, 2'd0, 2'd1, 1'b1, 1'b1);
    chk(s_fault && s_code == 1 && s_xw == 64'h8000_0001, "R4", "segment range", s_xw, 64'h8000_0001);
    run(64'h0000_0000_8000_0000, 2'd0, 2'd1, 1'b1, 1'b0);
    chk(s_fault && n_rd == 1, "R2", "31-bit fits segment", 64'(n_rd), 64'h1);
    desc_home = 64'h0010_0004;
    run(64'h0000_0400_0000_0000, 2'd0, 2'd3, 1'b1, 1'b1);
    chk(s_fault && s_code == 1 && s_xw == 64'h0000_0400_0000_0003, "R4", "third-region range", s_xw, 64'h0000_0400_0000_0003);
    desc_sec = 64'h0010_0008;
    run(64'h0020_0000_0000_0000, 2'd1, 2'd2, 1'b1, 1'b1);
    chk(s_fault && s_code == 1 && s_xw == 64'h0020_0000_0000_0002, "R4", "second-region range", s_xw, 64'h0020_0000_0000_0002);

    desc_pri = 64'h0000_0000_0005_0020; desc_sec = 64'h0010_0000;
    run(64'h0000_0000_0077_7000, 2'd2, 2'd2, 1'b1, 1'b1);
    chk(s_done && n_rd == 0 && s_ra == 64'h77_7000 && !s_r && s_x, "R5", "real-space via primary", s_ra, 64'h77_7000);

    v = 64'h0123_4567_89ab_c000;
    build(v, 2'd3, 9, 0, 1'b1, 64'h0002_5000, dsg);
    desc_pri = dsg; desc_sec = 64'h20; desc_home = 64'h20;
    run(v, 2'd0, 2'd1, 1'b1, 1'b1);
    chk(s_done && n_rd == 5 && s_ra == 64'h25000 && !s_w, "R6", "five-level walk", 64'(n_rd), 64'h5);
    run(v, 2'd1, 2'd1, 1'b1, 1'b1);
    chk(s_fault && s_code == 4 && s_xw == (v | 64'h5), "R9", "write to read-only", s_xw, v | 64'h5);
    build(v, 2'd3, 4, 1, 1'b0, 64'h0002_5000, dsg);
    desc_pri = dsg;
    run(v, 2'd0, 2'd1, 1'b1, 1'b1);
    chk(s_fault && s_code == 3, "R8", "page invalid", 64'(s_code), 64'h3);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] ty, kind, mode;
      logic [63:0] fr;
      bit wide;
      int lvl, ik;
      ty = 2'($urandom % 4);
      v = {$urandom, $urandom};
      if ($urandom % 8 != 0)
        v = (ty == 2) ? v & 64'h001f_ffff_ffff_ffff : (ty == 1) ? v & 64'h0000_03ff_ffff_ffff :
            (ty == 0) ? v & 64'h0000_0000_7fff_ffff : v;
      wide = ($urandom % 4 != 0);
      kind = 2'($urandom % 3);
      mode = 2'($urandom % 4);
      lvl = 3 - int'(ty) + int'($urandom % 5);
      ik = ($urandom % 3 == 0) ? 1 + int'($urandom % 2) : 0;
      case ($urandom % 3)
        0: fr = 64'($urandom % 2) << 12;
        1: fr = 64'($urandom % 64) << 12;
        default: fr = {$urandom, $urandom};
      endcase
      prefix = 64'($urandom % 80) << 12;
      build(wide ? v : {33'b0, v[30:0]}, ty, lvl, ik, ($urandom % 4 == 0), fr, dsg);
      desc_pri = 64'h20; desc_sec = 64'h20; desc_home = 64'h20;
      if ((mode == 2 && kind == 2) || mode == 0 || mode == 1) desc_pri = dsg;
      else if (mode == 2) desc_sec = dsg;
      else desc_home = dsg;
      run(v, kind, mode, ($urandom % 8 != 0), wide);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule